// File: doc/BRIEF.md
# Vectored Interrupt Status Controller

This block gathers the event lines of a two-channel serial peripheral into one interrupt request for a host processor. Up to four level-sensitive source conditions (by default: bit 0 channel A transmit-ready, bit 1 channel A receive-ready, bit 2 channel B transmit-ready, bit 3 channel B receive-ready) are visible in a read-only status view. A write-only enable mask shares the status address. Any source that is both active and enabled pulls the active-low request line low one clock later.

The processor answers the request with an acknowledge cycle. During that cycle the block places its programmable 8-bit vector on the read data bus. The vector sits at its own address, where it can be both read and written, and it returns to a fixed value on reset. Status bits follow the sources directly and are never latched. A request therefore clears by itself once the condition behind it goes away, for example after software drains a receive buffer.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A read (bus_sel=1, bus_wr=0, no acknowledge) of address 0 returns the current source levels in bits [NUM_SRC-1:0] and zero in all higher bits in the same cycle. Status is not sticky: once a source drops, its bit reads 0.
- R2: A write to address 0 loads the enable mask from bus_wdata[NUM_SRC-1:0] at that clock edge. It leaves the vector register unchanged.
- R3: irq_n goes low one clock after any source bit is 1 while its mask bit is 1. It returns high one clock after no such bit remains.
- R4: Under reset (rst_n=0, asynchronous) the mask is all zeros, irq_n is 1 and the vector equals VEC_RESET (default 0x0F).
- R5: Address 1 holds the 8-bit vector. A write there stores bus_wdata and a read returns the stored value.
- R6: While iack=1, bus_rdata shows the vector. This takes priority over any register read. A vector write in the same cycle is visible only after that clock edge, so the old vector is what the acknowledge returns.
- R7: A mask of 0x02 enables only the channel A receive-ready source (bit 1). Activity on bits 0, 2 and 3 then leaves irq_n high.
- R8: With no read and no acknowledge, bus_rdata is 0. Addresses 2 and 3 read as 0, and writes to them change neither the mask nor the vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NUM_SRC | Level-sensitive source conditions |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register select: 0 status/mask, 1 vector |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read or acknowledge data |
| iack | input | 1 | Interrupt-acknowledge cycle |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can meet in one cycle: an acknowledge cycle and a host write to the vector register. The bench provokes this by raising iack together with a vector write of a new value. It judges the result by requiring that the bus returns the old vector in that cycle and that a plain read afterwards returns the new one. A second overlap is a mask write while sources are already active; the bench checks that the request follows the new mask exactly one clock after the write edge.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
   // register select codes on bus_addr
   localparam int unsigned REG_STAT_MASK = 0;
   localparam int unsigned REG_VECTOR    = 1;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } bus_acc_e;

   function automatic bus_acc_e decode_access(input logic sel, input logic wr);
      if (!sel)    return ACC_IDLE;
      else if (wr) return ACC_WRITE;
      else         return ACC_READ;
   endfunction
endpackage

// File: rtl/irq_reg_file.sv
`timescale 1ns/1ps
module irq_reg_file
   import irq_vec_pkg::*;
#(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 2,
   parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [DATA_W-1:0]  vec_q
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT_MASK);
   localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(REG_VECTOR);

   bus_acc_e acc;
   logic     wr_mask;
   logic     wr_vec;

   always_comb begin
      acc     = decode_access(bus_sel, bus_wr);
      wr_mask = (acc == ACC_WRITE) && (bus_addr == A_STAT);
      wr_vec  = (acc == ACC_WRITE) && (bus_addr == A_VEC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         vec_q  <= VEC_RESET;
      end else begin
         if (wr_mask) mask_q <= bus_wdata[NUM_SRC-1:0];
         if (wr_vec)  vec_q  <= bus_wdata;
      end
   end

   assert_reset_values_R4: assert property (@(posedge clk)
      !rst_n |=> (mask_q == '0 && vec_q == VEC_RESET));

   assert_mask_write_keeps_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == A_STAT) |=> $stable(vec_q));

   assert_unused_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr != A_STAT && bus_addr != A_VEC)
         |=> ($stable(vec_q) && $stable(mask_q)));
endmodule

// File: rtl/irq_req_gen.sv
`timescale 1ns/1ps
module irq_req_gen #(
   parameter int unsigned NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic [NUM_SRC-1:0] mask_q,
   output logic               irq_n
);
   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
      assign hit[i] = src_evt[i] & mask_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= ~(|hit);
   end

   assert_reset_quiet_R4: assert property (@(posedge clk)
      !rst_n |=> irq_n);
endmodule

// File: rtl/irq_bus_mux.sv
`timescale 1ns/1ps
module irq_bus_mux
   import irq_vec_pkg::*;
#(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               iack,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic [DATA_W-1:0]  vec_q,
   output logic [DATA_W-1:0]  bus_rdata
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT_MASK);
   localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(REG_VECTOR);

   always_comb begin
      bus_rdata = '0;
      if (iack) begin
         bus_rdata = vec_q;
      end else if (decode_access(bus_sel, bus_wr) == ACC_READ) begin
         if (bus_addr == A_STAT)     bus_rdata[NUM_SRC-1:0] = src_evt;
         else if (bus_addr == A_VEC) bus_rdata = vec_q;
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 2,
   parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               iack,
   output logic               irq_n
);
   localparam logic [ADDR_W-1:0] A_STAT = '0;

   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC <= DATA_W)
         else $error("NUM_SRC must lie in 1..DATA_W");
      assert (ADDR_W >= 1)
         else $error("ADDR_W must be at least 1");
   end

   logic [NUM_SRC-1:0] mask_q;
   logic [DATA_W-1:0]  vec_q;

   irq_reg_file #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_RESET(VEC_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mask_q(mask_q), .vec_q(vec_q)
   );

   irq_req_gen #(.NUM_SRC(NUM_SRC)) u_req (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .mask_q(mask_q), .irq_n(irq_n)
   );

   irq_bus_mux #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_mux (
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .iack(iack),
      .src_evt(src_evt), .vec_q(vec_q), .bus_rdata(bus_rdata)
   );

   assert_ack_drives_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iack |-> (bus_rdata == vec_q));

   assert_status_follows_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !iack && bus_addr == A_STAT)
         |-> (bus_rdata[NUM_SRC-1:0] == src_evt));

   assert_irq_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> $past(|(src_evt & mask_q)));

   assert_zero_mask_quiets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == A_STAT && bus_wdata[NUM_SRC-1:0] == '0)
         |=> ##1 irq_n);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] src_evt = '0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       iack = 1'b0;
   logic       irq_n;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .iack(iack), .irq_n(irq_n)
   );

   // upper nibble = source pattern, lower nibble = mask
   localparam logic [7:0] PAT_TBL [8] = '{
      8'h22, 8'h12, 8'hD2, 8'hF2, 8'h0F, 8'h8F, 8'h5A, 8'hFF
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic read_check(input string req, input logic [1:0] a, input logic [7:0] exp);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 check(req, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic irq_check(input string req, input logic exp);
      @(posedge clk);
      #1 check(req, {7'd0, irq_n}, {7'd0, exp});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 check("R4 irq idle in reset", {7'd0, irq_n}, 8'h01);
      @(negedge clk) rst_n = 1'b1;
      #1 check("R8 idle bus reads zero", bus_rdata, 8'h00);
      read_check("R4 R5 vector reset value", 2'd1, 8'h0F);
      read_check("R1 status empty", 2'd0, 8'h00);
      @(negedge clk) src_evt = 4'hF;
      irq_check("R4 reset mask blocks all", 1'b1);

      // table-driven mask/source sweep
      for (int k = 0; k < 8; k++) begin
         logic [3:0] s, m;
         s = PAT_TBL[k][7:4];
         m = PAT_TBL[k][3:0];
         bus_write(2'd0, {4'd0, m});
         src_evt = s;
         irq_check((m == 4'h2) ? "R7 rx-ready-only mask" : "R2 R3 masked request", ~|(s & m));
         read_check("R1 status mirrors sources", 2'd0, {4'd0, s});
      end

      // non-sticky behaviour
      bus_write(2'd0, 8'h0F);
      src_evt = 4'h2;
      irq_check("R3 request asserts", 1'b0);
      @(negedge clk) src_evt = 4'h0;
      irq_check("R3 request releases", 1'b1);
      read_check("R1 status not sticky", 2'd0, 8'h00);

      // vector register
      bus_write(2'd1, 8'hA5);
      read_check("R5 vector readback", 2'd1, 8'hA5);
      bus_write(2'd0, 8'h00);
      read_check("R2 mask write keeps vector", 2'd1, 8'hA5);

      // acknowledge cycles
      @(negedge clk) iack = 1'b1;
      #1 check("R6 ack drives vector", bus_rdata, 8'hA5);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; src_evt = 4'h3;
      #1 check("R6 ack beats status read", bus_rdata, 8'hA5);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h40;
      #1 check("R6 ack with vector write shows old", bus_rdata, 8'hA5);
      @(negedge clk);
      iack = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      read_check("R6 R5 vector updated after ack", 2'd1, 8'h40);

      // unused addresses
      bus_write(2'd2, 8'hFF);
      bus_write(2'd3, 8'hFF);
      read_check("R8 unused address reads zero", 2'd2, 8'h00);
      read_check("R8 unused write keeps vector", 2'd1, 8'h40);
      @(negedge clk) src_evt = 4'hF;
      irq_check("R8 unused write keeps mask", 1'b1);

      // mask write while sources already active
      bus_write(2'd0, 8'h08);
      irq_check("R3 late enable asserts", 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule